// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that moves data by following a chain of descriptors kept in memory. Software writes the descriptors and gives the channel the address of the first one together with its byte count. The channel then reads each descriptor as a burst of eight words and copies that descriptor's bytes one 32-bit word at a time: a read beat from the source, then a write beat to the destination. When the descriptor is finished, the channel follows its link word. A link of zero stops the chain. A link that points back to an earlier descriptor makes the chain loop.

Each side of a transfer, source and destination, can hold a fixed address, such as a peripheral data register, or an incrementing one. In two-dimensional mode the incrementing side walks lines: at the end of each line it jumps from the start of that line by the side's stride. A descriptor can ask for a one-cycle completion event. It can also ask the channel to halt when it finishes, until a resume pulse arrives. A paced descriptor moves each word only while a chosen request input is high. The current descriptor pointer, with the channel status in its low bits, and the bytes left in the current descriptor can be read at any time.

Top module: `dma_chain_channel`

## Requirements
- R1: After a synchronous reset the channel is idle. `cur_desc` reads 0, `residue` reads 0, and `mem_req`, `done_evt` and `pause_evt` are low.
- R2: When `start` is sampled high while the channel is idle, `cur_desc` takes `start_addr` (32-byte aligned) and `residue` takes `start_count`. Both are readable on the next cycle, before any descriptor word has been read. A `start` pulse while the channel is not idle is ignored.
- R3: Descriptor fetch is eight single-word reads at the descriptor address plus 0, 4, … 28. The words are, in order: link, control, byte size, source address, destination address, line length, source stride, destination stride.
- R4: Control bit 0 set makes the source address increment by 4 per word. Clear, the source address stays fixed. Control bit 1 does the same for the destination.
- R5: Control bit 4 selects 2D addressing. A line holds ceil(line/4) words, and one word when the line length is 0. After the last word of a line, an incrementing side moves to its line start plus its stride. In 1D mode the line length is the byte size. Only the byte size decides when the descriptor ends.
- R6: `done_evt` pulses for one cycle at the end of a descriptor whose control bit 2 (notify) or bit 3 (halt) is set. `pause_evt` pulses in the same cycle when bit 3 is set.
- R7: After a descriptor with bit 3 set, the status field reads 2 (paused) and the channel makes no memory request until `resume`. It then follows that descriptor's link.
- R8: At the end of a descriptor (or on resume), a link of zero makes the channel idle with `cur_desc` still holding the last descriptor address. A nonzero link is loaded into `cur_desc` and fetched, so a link back to an earlier descriptor loops the chain.
- R9: With control bit 5 (paced) set, no source read is issued while `req_lines[ctrl[11:8]]` is low. The descriptor's bytes stay pending and `residue` is unchanged.
- R10: `cur_desc[1:0]` gives the status: 0 idle, 1 running, 2 paused. `cur_desc[31:5]` holds the descriptor pointer. `residue` is reloaded with the byte size at each descriptor load and drops by 4 on every accepted write beat.
- R11: A memory request with `mem_ready` low keeps `mem_req`, `mem_we` and `mem_addr` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_addr | input | 32 | Address of first descriptor, 32-byte aligned |
| start_count | input | 32 | Byte size of first descriptor, preloaded into residue |
| resume | input | 1 | Leaves the paused state and follows the link |
| req_lines | input | NREQ | Peripheral request inputs for paced descriptors |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for write beat, 0 for read beat |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Beat accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| done_evt | output | 1 | One-cycle completion event |
| pause_evt | output | 1 | One-cycle halt event |
| cur_desc | output | 32 | Descriptor pointer with status in bits 1:0 |
| residue | output | 32 | Bytes left in the current descriptor |

## Verification
The bench drives a three-descriptor chain. It mixes incrementing and fixed sources, a halt descriptor and a 2D descriptor, while the memory stalls on every fourth cycle. A channel that dropped an address during a stall, or that reset the line start wrongly, would write wrong words or write them to wrong addresses, and the scoreboard reports each one. The 2D cases with a zero line length and a line length that is not a multiple of four catch a line counter that never wraps. A paced descriptor is held with its request input low, so a channel that ignored the selected line would write too early. A two-node loop that is resumed once shows whether the link back is followed or the chain stops after one pass. The bench also checks the residue on the cycle right after start, which a channel that loaded the count only at fetch would fail.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int WORD_BYTES      = 4;
    localparam int DESC_WORDS      = 8;
    localparam int DESC_IDX_W      = $clog2(DESC_WORDS);
    localparam int DESC_ALIGN_BITS = 5;

    // word positions inside a descriptor
    localparam int W_LINK    = 0;
    localparam int W_CTRL    = 1;
    localparam int W_SIZE    = 2;
    localparam int W_SRC     = 3;
    localparam int W_DST     = 4;
    localparam int W_LINE    = 5;
    localparam int W_SSTRIDE = 6;
    localparam int W_DSTRIDE = 7;

    // control word bit positions
    localparam int CB_SRC_INC = 0;
    localparam int CB_DST_INC = 1;
    localparam int CB_NOTIFY  = 2;
    localparam int CB_HOLD    = 3;
    localparam int CB_TWO_D   = 4;
    localparam int CB_PACED   = 5;
    localparam int CB_REQ_LSB = 8;
    localparam int REQ_SEL_W  = 4;

    typedef logic [31:0] word_t;

    typedef struct packed {
        word_t link;
        word_t ctrl;
        word_t size;
        word_t src;
        word_t dst;
        word_t line;
        word_t sstride;
        word_t dstride;
    } desc_t;

    typedef struct packed {
        logic                 src_inc;
        logic                 dst_inc;
        logic                 notify;
        logic                 hold;
        logic                 two_d;
        logic                 paced;
        logic [REQ_SEL_W-1:0] req_sel;
    } ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_LOAD, S_RD, S_WR, S_END, S_HOLD
    } chan_state_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_PAUSED = 2'd2
    } chan_status_e;

    function automatic ctrl_t decode_ctrl(input word_t w);
        ctrl_t c;
        c.src_inc = w[CB_SRC_INC];
        c.dst_inc = w[CB_DST_INC];
        c.notify  = w[CB_NOTIFY];
        c.hold    = w[CB_HOLD];
        c.two_d   = w[CB_TWO_D];
        c.paced   = w[CB_PACED];
        c.req_sel = w[CB_REQ_LSB +: REQ_SEL_W];
        return c;
    endfunction

    function automatic chan_status_e status_of(input chan_state_e s);
        case (s)
            S_IDLE:  return ST_IDLE;
            S_HOLD:  return ST_PAUSED;
            default: return ST_RUN;
        endcase
    endfunction

endpackage

// File: rtl/dmac_desc_fetch.sv
module dmac_desc_fetch
    import dmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  word_t base,
    input  logic  ready,
    input  word_t rdata,
    output logic  rd_req,
    output word_t rd_addr,
    output logic  done,
    output desc_t desc
);

    logic [DESC_IDX_W-1:0] idx_q;
    word_t                 words_q [DESC_WORDS];

    assign rd_req  = active;
    assign rd_addr = {base[31:DESC_ALIGN_BITS], idx_q, 2'b00};
    assign done    = active && ready && (idx_q == DESC_IDX_W'(DESC_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            idx_q <= '0;
        end else if (ready) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar i = 0; i < DESC_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[i] <= '0;
            end else if (active && ready && idx_q == DESC_IDX_W'(i)) begin
                words_q[i] <= rdata;
            end
        end
    end

    always_comb begin
        desc.link    = words_q[W_LINK];
        desc.ctrl    = words_q[W_CTRL];
        desc.size    = words_q[W_SIZE];
        desc.src     = words_q[W_SRC];
        desc.dst     = words_q[W_DST];
        desc.line    = words_q[W_LINE];
        desc.sstride = words_q[W_SSTRIDE];
        desc.dstride = words_q[W_DSTRIDE];
    end

    // R3: fetch beats walk the descriptor one word at a time
    a_r3_fetch_order: assert property (@(posedge clk) disable iff (rst)
        (active && ready && !done) |=> (rd_addr == $past(rd_addr) + 32'd4))
        else $error("fetch address did not advance by one word");

    // R2: descriptor pointers are 32-byte aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        active |-> (base[DESC_ALIGN_BITS-1:0] == '0))
        else $error("descriptor pointer not aligned");

endmodule

// File: rtl/dmac_addr_gen.sv
module dmac_addr_gen
    import dmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t base,
    input  word_t line_len,
    input  word_t stride,
    input  logic  incr,
    input  logic  step,
    output word_t addr
);

    word_t addr_q;
    word_t line_start_q;
    word_t left_q;
    logic  line_end;

    assign line_end = (left_q <= word_t'(WORD_BYTES));
    assign addr     = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q       <= '0;
            line_start_q <= '0;
            left_q       <= '0;
        end else if (load) begin
            addr_q       <= base;
            line_start_q <= base;
            left_q       <= line_len;
        end else if (step && incr) begin
            if (line_end) begin
                addr_q       <= line_start_q + stride;
                line_start_q <= line_start_q + stride;
                left_q       <= line_len;
            end else begin
                addr_q <= addr_q + word_t'(WORD_BYTES);
                left_q <= left_q - word_t'(WORD_BYTES);
            end
        end
    end

    // R4: a fixed side never moves
    a_r4_fixed_hold: assert property (@(posedge clk) disable iff (rst)
        (step && !incr && !load) |=> $stable(addr))
        else $error("fixed address moved");

    // R5: inside a line the address advances one word
    a_r5_in_line: assert property (@(posedge clk) disable iff (rst)
        (step && incr && !load && !line_end) |=> (addr == $past(addr) + 32'd4))
        else $error("address did not advance inside line");

endmodule

// File: rtl/dmac_pace.sv
module dmac_pace
    import dmac_pkg::*;
#(
    parameter int NREQ = 4
) (
    input  logic [NREQ-1:0]      lines,
    input  logic [REQ_SEL_W-1:0] sel,
    input  logic                 paced,
    output logic                 grant
);

    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (sel == REQ_SEL_W'(i)) hit = lines[i];
        end
    end

    assign grant = !paced || hit;

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dmac_pkg::*;
#(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [31:0]     start_addr,
    input  logic [31:0]     start_count,
    input  logic            resume,
    input  logic [NREQ-1:0] req_lines,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ready,
    input  logic [31:0]     mem_rdata,
    output logic            done_evt,
    output logic            pause_evt,
    output logic [31:0]     cur_desc,
    output logic [31:0]     residue
);

    localparam int SIDES = 2;   // 0 = source, 1 = destination

    chan_state_e state_q;
    word_t       ptr_q;
    word_t       residue_q;
    word_t       data_q;

    desc_t desc;
    ctrl_t ctl;
    logic  fetch_done;
    logic  f_req;
    word_t f_addr;
    logic  grant;
    logic  gen_load;
    logic  gen_step;
    word_t line_len;
    logic  follow;

    word_t side_base   [SIDES];
    word_t side_stride [SIDES];
    logic  side_inc    [SIDES];
    word_t side_addr   [SIDES];

    assign ctl      = decode_ctrl(desc.ctrl);
    assign gen_load = (state_q == S_LOAD);
    assign gen_step = (state_q == S_WR) && mem_ready;
    assign line_len = ctl.two_d ? desc.line : desc.size;
    assign follow   = ((state_q == S_END) && !ctl.hold) ||
                      ((state_q == S_HOLD) && resume);

    dmac_desc_fetch u_fetch (
        .clk     (clk),
        .rst     (rst),
        .active  (state_q == S_FETCH),
        .base    (ptr_q),
        .ready   (mem_ready),
        .rdata   (mem_rdata),
        .rd_req  (f_req),
        .rd_addr (f_addr),
        .done    (fetch_done),
        .desc    (desc)
    );

    always_comb begin
        side_base[0]   = desc.src;
        side_stride[0] = desc.sstride;
        side_inc[0]    = ctl.src_inc;
        side_base[1]   = desc.dst;
        side_stride[1] = desc.dstride;
        side_inc[1]    = ctl.dst_inc;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dmac_addr_gen u_gen (
            .clk      (clk),
            .rst      (rst),
            .load     (gen_load),
            .base     (side_base[s]),
            .line_len (line_len),
            .stride   (side_stride[s]),
            .incr     (side_inc[s]),
            .step     (gen_step),
            .addr     (side_addr[s])
        );
    end

    dmac_pace #(.NREQ(NREQ)) u_pace (
        .lines (req_lines),
        .sel   (ctl.req_sel),
        .paced (ctl.paced),
        .grant (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            ptr_q     <= '0;
            residue_q <= '0;
            data_q    <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        ptr_q     <= start_addr;
                        residue_q <= start_count;
                        state_q   <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (fetch_done) state_q <= S_LOAD;
                end
                S_LOAD: begin
                    residue_q <= desc.size;
                    state_q   <= (desc.size == '0) ? S_END : S_RD;
                end
                S_RD: begin
                    if (grant && mem_ready) begin
                        data_q  <= mem_rdata;
                        state_q <= S_WR;
                    end
                end
                S_WR: begin
                    if (mem_ready) begin
                        if (residue_q <= word_t'(WORD_BYTES)) begin
                            residue_q <= '0;
                            state_q   <= S_END;
                        end else begin
                            residue_q <= residue_q - word_t'(WORD_BYTES);
                            state_q   <= S_RD;
                        end
                    end
                end
                S_END: begin
                    if (ctl.hold) state_q <= S_HOLD;
                end
                default: ;
            endcase

            if (follow) begin
                if (desc.link == '0) begin
                    state_q <= S_IDLE;
                end else begin
                    ptr_q   <= desc.link;
                    state_q <= S_FETCH;
                end
            end
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            S_FETCH: begin
                mem_req  = f_req;
                mem_addr = f_addr;
            end
            S_RD: begin
                mem_req  = grant;
                mem_addr = side_addr[0];
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = side_addr[1];
                mem_wdata = data_q;
            end
            default: ;
        endcase
    end

    assign done_evt  = (state_q == S_END) && (ctl.notify || ctl.hold);
    assign pause_evt = (state_q == S_END) && ctl.hold;
    assign cur_desc  = {ptr_q[31:DESC_ALIGN_BITS], {(DESC_ALIGN_BITS-2){1'b0}},
                        status_of(state_q)};
    assign residue   = residue_q;

    // R6: a halt event always carries a completion event
    a_r6_pause_has_done: assert property (@(posedge clk) disable iff (rst)
        pause_evt |-> done_evt)
        else $error("pause event without completion event");

    // R7: no memory traffic while paused
    a_r7_paused_quiet: assert property (@(posedge clk) disable iff (rst)
        (cur_desc[1:0] == 2'd2) |-> !mem_req)
        else $error("memory request while paused");

    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (cur_desc[1:0] == 2'd0) |-> !mem_req)
        else $error("memory request while idle");

    // R9: a paced read needs its request line
    a_r9_paced_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && state_q == S_RD && ctl.paced)
            |-> req_lines[ctl.req_sel[$clog2(NREQ)-1:0]])
        else $error("paced read without request");

    // R10: each accepted write removes one word from the residue
    a_r10_residue_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready)
            |=> (residue == $past(residue) - 32'd4 || residue == '0))
        else $error("residue did not drop by one word");

    // R11: a stalled request is held unchanged
    a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready)
            |=> (mem_req && $stable(mem_we) && $stable(mem_addr)))
        else $error("stalled request changed");

    // R2: start pointer and links are aligned
    a_r2_start_aligned: assert property (@(posedge clk) disable iff (rst)
        (start && state_q == S_IDLE) |-> (start_addr[DESC_ALIGN_BITS-1:0] == '0))
        else $error("start address not aligned");

    a_r8_link_aligned: assert property (@(posedge clk) disable iff (rst)
        follow |-> (desc.link[DESC_ALIGN_BITS-1:0] == '0))
        else $error("link not aligned");

endmodule

// File: tb/sim_dma_chain_channel.sv
module sim_dma_chain_channel;

    localparam int CLK_PERIOD = 10;
    localparam int NREQ       = 4;
    localparam int MEM_WORDS  = 1024;
    localparam int WATCHDOG   = 100000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [31:0]     start_addr = '0;
    logic [31:0]     start_count = '0;
    logic            resume = 1'b0;
    logic [NREQ-1:0] req_lines = '0;
    logic            mem_req, mem_we, mem_ready;
    logic [31:0]     mem_addr, mem_wdata, mem_rdata;
    logic            done_evt, pause_evt;
    logic [31:0]     cur_desc, residue;

    logic [31:0] mem [MEM_WORDS];
    logic [1:0]  rdy_cnt = 2'd0;

    int checks = 0;
    int fails  = 0;
    int n_done = 0, n_pause = 0, n_req = 0, n_wr = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } exp_t;
    exp_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chain_channel #(.NREQ(NREQ)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_count(start_count), .resume(resume), .req_lines(req_lines),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done_evt(done_evt), .pause_evt(pause_evt), .cur_desc(cur_desc),
        .residue(residue)
    );

    // behavioural memory: one stall every fourth cycle
    assign mem_ready = (rdy_cnt != 2'd3);
    assign mem_rdata = mem[mem_addr[11:2]];
    always @(negedge clk) rdy_cnt <= rdy_cnt + 2'd1;
    always @(posedge clk) if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done_evt)  n_done++;
            if (pause_evt) n_pause++;
            if (mem_req)   n_req++;
            if (mem_req && mem_we && mem_ready) begin
                n_wr++;
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected write", mem_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(mem_addr == e.a, {e.tag, " write address"}, mem_addr, e.a);
                    check(mem_wdata == e.d, {e.tag, " write data"}, mem_wdata, e.d);
                end
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] side_addr(input logic [31:0] base, input bit inc,
        input bit two_d, input int size, input int line, input int stride, input int w);
        int wpl;
        if (!inc) return base;
        if (two_d) wpl = (line == 0) ? 1 : (line + 3) / 4;
        else       wpl = (size / 4 == 0) ? 1 : size / 4;
        return base + 32'((w / wpl) * stride + 4 * (w % wpl));
    endfunction

    task automatic put_desc(input int at, input logic [31:0] link, input logic [31:0] ctl,
        input int size, input logic [31:0] src, input logic [31:0] dst,
        input int line, input int ss, input int ds);
        int b;
        b = at / 4;
        mem[b+0] = link;
        mem[b+1] = ctl;
        mem[b+2] = 32'(size);
        mem[b+3] = src;
        mem[b+4] = dst;
        mem[b+5] = 32'(line);
        mem[b+6] = 32'(ss);
        mem[b+7] = 32'(ds);
    endtask

    // driver: pushes the expected writes of one descriptor
    task automatic push_node(input logic [31:0] ctl, input int size, input logic [31:0] src,
        input logic [31:0] dst, input int line, input int ss, input int ds, input string tag);
        for (int w = 0; w < (size + 3) / 4; w++) begin
            logic [31:0] sa, da;
            exp_t e;
            sa = side_addr(src, ctl[0], ctl[4], size, line, ss, w);
            da = side_addr(dst, ctl[1], ctl[4], size, line, ds, w);
            e.a = da;
            e.d = mem[sa[11:2]];
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_done = 0; n_pause = 0; n_req = 0; n_wr = 0;
    endtask

    task automatic go(input logic [31:0] addr, input logic [31:0] cnt);
        @(negedge clk);
        start = 1'b1; start_addr = addr; start_count = cnt;
        @(negedge clk);
        start = 1'b0;
        check(residue == cnt, "R2 residue preloaded before fetch", residue, cnt);
        check(cur_desc == (addr | 32'd1), "R2 pointer and running status", cur_desc, addr | 32'd1);
        check(mem_req && !mem_we && mem_addr == addr, "R3 first fetch address", mem_addr, addr);
    endtask

    task automatic wait_status(input logic [1:0] st, input string tag);
        int n;
        n = 0;
        while (cur_desc[1:0] != st && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(cur_desc[1:0] == st, tag, {30'd0, cur_desc[1:0]}, {30'd0, st});
    endtask

    task automatic pulse_resume();
        @(negedge clk);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
    endtask

    initial begin
        int req_mark, wr_mark;
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'(i) * 32'h9E3779B1 + 32'h17;

        // ---- R1 reset state
        do_reset();
        check(cur_desc == 32'h0, "R1 cur_desc after reset", cur_desc, 32'h0);
        check(residue == 32'h0, "R1 residue after reset", residue, 32'h0);
        check(!mem_req && !done_evt && !pause_evt, "R1 outputs quiet after reset",
              {29'd0, mem_req, done_evt, pause_evt}, 32'h0);

        // ---- chain: 1D notify, fixed-source halt, 2D
        put_desc(32'h100, 32'h120, 32'h07, 16, 32'h400, 32'h800, 0, 0, 0);
        put_desc(32'h120, 32'h140, 32'h0A, 8, 32'h600, 32'h900, 0, 0, 0);
        put_desc(32'h140, 32'h000, 32'h13, 24, 32'h480, 32'hA00, 8, 16, 12);
        push_node(32'h07, 16, 32'h400, 32'h800, 0, 0, 0, "R4 1D increment");
        push_node(32'h0A, 8, 32'h600, 32'h900, 0, 0, 0, "R4 fixed source");
        push_node(32'h13, 24, 32'h480, 32'hA00, 8, 16, 12, "R5 2D stride");
        go(32'h100, 32'd16);
        // start while busy must be ignored
        @(negedge clk);
        start = 1'b1; start_addr = 32'h300; start_count = 32'd4;
        @(negedge clk);
        start = 1'b0;
        check(cur_desc == 32'h101, "R2 start ignored while busy", cur_desc, 32'h101);
        wait_status(2'd2, "R7 status paused after halt node");
        check(cur_desc[31:5] == 27'(32'h120 >> 5), "R7 pointer at halt node",
              cur_desc & 32'hFFFF_FFE0, 32'h120);
        check(n_done == 2, "R6 completion events so far", 32'(n_done), 32'd2);
        check(n_pause == 1, "R6 halt event count", 32'(n_pause), 32'd1);
        req_mark = n_req;
        repeat (12) @(negedge clk);
        check(n_req == req_mark, "R7 no memory request while paused", 32'(n_req), 32'(req_mark));
        pulse_resume();
        wait_status(2'd0, "R8 idle after zero link");
        check(cur_desc == 32'h140, "R8 pointer keeps last descriptor", cur_desc, 32'h140);
        check(residue == 32'h0, "R10 residue empty at chain end", residue, 32'h0);
        check(n_done == 2, "R6 no event for plain node", 32'(n_done), 32'd2);
        check(sb.size() == 0, "R3 all chain writes seen", 32'(sb.size()), 32'h0);

        // ---- paced descriptor on request line 2
        do_reset();
        put_desc(32'h180, 32'h000, 32'h227, 8, 32'h440, 32'hB00, 0, 0, 0);
        push_node(32'h227, 8, 32'h440, 32'hB00, 0, 0, 0, "R9 paced data");
        req_lines = 4'b1011;
        go(32'h180, 32'd8);
        wr_mark = n_wr;
        repeat (40) @(negedge clk);
        check(n_wr == wr_mark, "R9 no transfer while request low", 32'(n_wr), 32'(wr_mark));
        check(residue == 32'd8, "R9 residue held while request low", residue, 32'd8);
        req_lines = 4'b0100;
        wait_status(2'd0, "R9 paced node completes");
        check(n_done == 1, "R6 paced notify event", 32'(n_done), 32'd1);
        check(sb.size() == 0, "R9 paced writes seen", 32'(sb.size()), 32'h0);
        req_lines = '0;

        // ---- 2D early line ends: non-multiple and zero line length
        do_reset();
        put_desc(32'h1A0, 32'h1C0, 32'h13, 16, 32'h400, 32'hC00, 6, 32, 8);
        put_desc(32'h1C0, 32'h000, 32'h13, 8, 32'h400, 32'hC40, 0, 64, 16);
        push_node(32'h13, 16, 32'h400, 32'hC00, 6, 32, 8, "R5 line not word multiple");
        push_node(32'h13, 8, 32'h400, 32'hC40, 0, 64, 16, "R5 zero line length");
        go(32'h1A0, 32'd16);
        wait_status(2'd0, "R5 2D chain ends on size");
        check(sb.size() == 0, "R5 2D writes seen", 32'(sb.size()), 32'h0);

        // ---- circular chain: A -> B(halt) -> A
        do_reset();
        put_desc(32'h200, 32'h220, 32'h07, 4, 32'h408, 32'hD00, 0, 0, 0);
        put_desc(32'h220, 32'h200, 32'h0B, 4, 32'h40C, 32'hD04, 0, 0, 0);
        push_node(32'h07, 4, 32'h408, 32'hD00, 0, 0, 0, "R8 loop pass one");
        push_node(32'h0B, 4, 32'h40C, 32'hD04, 0, 0, 0, "R8 loop pass one");
        push_node(32'h07, 4, 32'h408, 32'hD00, 0, 0, 0, "R8 loop pass two");
        push_node(32'h0B, 4, 32'h40C, 32'hD04, 0, 0, 0, "R8 loop pass two");
        go(32'h200, 32'd4);
        wait_status(2'd2, "R8 first pass halts");
        pulse_resume();
        check(cur_desc == 32'h201, "R8 link back to first node", cur_desc, 32'h201);
        wait_status(2'd2, "R8 second pass halts");
        check(n_done == 4, "R8 events across two passes", 32'(n_done), 32'd4);
        check(sb.size() == 0, "R8 loop writes seen", 32'(sb.size()), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule